// File: doc/BRIEF.md
# USB 2.0 Suspend Wake Walker

This block keeps watch over a suspended USB 2.0 port while the host controller beside it is power-gated. It filters the port's D+ and D- line levels through a programmable debounce filter. It then tests the filtered state against a wake-trigger selector. When a qualifying event arrives and wake detection is armed, it latches a sticky wake alarm. It also starts a walk through four pad-control phases, named A, B, C and D.

Every phase has a control byte that drives the pad: a pull-down on each line, a drive-high on each line, and high-Z. The four bytes depend on the saved port speed. Phase A holds the idle (J) level and phases B to D drive the resume (K) level, so the walker settles in phase D and keeps resume signalling on the bus. It stays there until software clears the walk pointer. The wake alarm stays set until it gets its own clear pulse. All configuration arrives on plain input ports.

Top module: `usb_wake_walker`

## Requirements
- R1: In the cycle after a synchronous reset, `phase` is 0, `wake_alarm` is 0, and the pad outputs show the phase-A byte for the current speed. The debounced line state takes the present line levels during reset.
- R2: A pad-control byte uses these bits: bit 0 = D+ pull-down, bit 1 = D- pull-down, bit 4 = drive D+ high, bit 5 = drive D- high, bit 6 = high-Z. Phase A is byte 0 of the table word and phase D is byte 3. The pad outputs always show the byte of the phase on `phase`.
- R3: Speed code 0 (high) and code 1 (full) give phase-A byte 0x53 (J: high-Z with D+ driven) and byte 0x23 (K: D- driven) in phases B, C and D.
- R4: Speed code 2 (low) has the inverse polarity: phase-A byte 0x63 and byte 0x13 in phases B to D.
- R5: Speed code 3 (reset/unknown) gives byte 0x43 in all four phases: high-Z, both pull-downs, no drive.
- R6: A change of the raw line pair is accepted into the debounced state only after it has held steady for `deb_cnt`+1 clock edges. A shorter glitch is ignored.
- R7: The wake-trigger codes are as follows. Code 15 wakes on any change of the debounced pair. Codes 0 to 3 wake while the debounced pair {D+,D-} equals the code. Code 12 and every other code never wake.
- R8: The wake alarm sets only while `master_en` and `line_wake_en` are both 1. Once set it stays set until a `clr_alarm` pulse, and the clear wins over a wake in the same cycle.
- R9: After a wake, the phase advances by one every `step_ticks`+1 cycles and then holds at phase D (3).
- R10: A `clr_ptr` pulse returns the walker to phase A and stops the walk. It wins over a wake in the same cycle.
- R11: While `master_en` is 0, `phase` reads 0 and the walker is frozen. When it is enabled again, the walk continues from the phase it had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_dp | input | 1 | Raw D+ level |
| line_dm | input | 1 | Raw D- level |
| speed | input | 2 | Saved port speed code |
| wake_sel | input | 4 | Wake-trigger selector |
| master_en | input | 1 | Master enable of the walker |
| line_wake_en | input | 1 | Line wake latch enable |
| deb_cnt | input | DEB_W | Debounce count |
| step_ticks | input | TICK_W | Cycles per phase minus one |
| clr_ptr | input | 1 | Pulse: return walker to phase A |
| clr_alarm | input | 1 | Pulse: clear wake alarm |
| pad_pd_dp | output | 1 | D+ pull-down |
| pad_pd_dm | output | 1 | D- pull-down |
| pad_drv_dp | output | 1 | Drive D+ high |
| pad_drv_dm | output | 1 | Drive D- high |
| pad_hiz | output | 1 | High-Z |
| phase | output | 2 | Current walk phase (0 = A) |
| wake_alarm | output | 1 | Latched wake alarm |

## Verification
The hardest state to reach is a walk that has stopped partway: the master enable drops after the walker has left phase A but before it reaches phase D, and is later raised again. In that case the output shows phase A while the pointer it hides must keep its value. The stimulus raises a wake with a long step count, waits for the phase to leave A, and then toggles the master enable. A cycle-by-cycle model checks both the frozen interval and the resumed walk. Debounce glitches just under the threshold, and a clear arriving in the same cycle as a wake, are also driven on purpose.

// File: rtl/usb_walk_pkg.sv
// Package: shared encodings for the suspend wake walker.
// Assumes: pad byte layout and speed codes are fixed by the pad neighbour.
package usb_walk_pkg;
    localparam int NUM_PHASES = 4;
    localparam int BYTE_W     = 8;
    localparam int TABLE_W    = NUM_PHASES * BYTE_W;

    localparam int BIT_PD_DP  = 0;
    localparam int BIT_PD_DM  = 1;
    localparam int BIT_DRV_DP = 4;
    localparam int BIT_DRV_DM = 5;
    localparam int BIT_HIZ    = 6;

    typedef enum logic [1:0] {
        SPD_HIGH = 2'd0,
        SPD_FULL = 2'd1,
        SPD_LOW  = 2'd2,
        SPD_UNK  = 2'd3
    } speed_e;

    localparam logic [3:0] WAKE_NEVER = 4'd12;
    localparam logic [3:0] WAKE_ANY   = 4'd15;

    typedef struct packed {
        logic hiz;
        logic drv_dm;
        logic drv_dp;
        logic pd_dm;
        logic pd_dp;
    } pad_ctl_t;

    // Build one pad byte from its fields.
    function automatic logic [BYTE_W-1:0] pad_byte(input logic hiz, input logic ddm,
                                                   input logic ddp);
        logic [BYTE_W-1:0] b;
        b             = '0;
        b[BIT_PD_DP]  = 1'b1;
        b[BIT_PD_DM]  = 1'b1;
        b[BIT_DRV_DP] = ddp;
        b[BIT_DRV_DM] = ddm;
        b[BIT_HIZ]    = hiz;
        return b;
    endfunction

    // Compose the four-phase table word for a speed code.
    function automatic logic [TABLE_W-1:0] phase_table(input speed_e spd);
        logic [BYTE_W-1:0] first, rest;
        case (spd)
            SPD_HIGH, SPD_FULL: begin
                first = pad_byte(1'b1, 1'b0, 1'b1);
                rest  = pad_byte(1'b0, 1'b1, 1'b0);
            end
            SPD_LOW: begin
                first = pad_byte(1'b1, 1'b1, 1'b0);
                rest  = pad_byte(1'b0, 1'b0, 1'b1);
            end
            default: begin
                first = pad_byte(1'b1, 1'b0, 1'b0);
                rest  = first;
            end
        endcase
        return {rest, rest, rest, first};
    endfunction
endpackage

// File: rtl/uww_line_filter.sv
// Line filter: debounces the raw D+/D- pair.
// Assumes: inputs already synchronous to clk; a change must be held
// deb_cnt+1 edges to be accepted. Reset loads the present line levels.
module uww_line_filter #(
    parameter int DEB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       raw,
    input  logic [DEB_W-1:0] deb_cnt,
    output logic [1:0]       stable,
    output logic [1:0]       stable_q
);
    logic [DEB_W-1:0] run_cnt;

    // Count steady cycles of a differing raw value and accept it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable  <= raw;
            run_cnt <= '0;
        end else if (raw == stable) begin
            run_cnt <= '0;
        end else if (run_cnt >= deb_cnt) begin
            stable  <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Keep the previous debounced value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stable_q <= raw;
        else        stable_q <= stable;
    end
endmodule

// File: rtl/uww_wake_detect.sv
// Wake detector: matches the debounced pair against the trigger code and
// keeps the sticky alarm. Assumes clear pulses are one cycle wide.
module uww_wake_detect
    import usb_walk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] stable,
    input  logic [1:0] stable_q,
    input  logic [3:0] wake_sel,
    input  logic       master_en,
    input  logic       line_wake_en,
    input  logic       clr_alarm,
    output logic       wake_evt,
    output logic       alarm
);
    logic hit;

    // Decide whether the current line state matches the selected trigger.
    always_comb begin
        if (wake_sel == WAKE_ANY)       hit = (stable != stable_q);
        else if (wake_sel[3:2] == 2'b00) hit = (stable == wake_sel[1:0]);
        else                             hit = 1'b0;
    end

    assign wake_evt = hit && master_en && line_wake_en;

    // Latch the alarm; the clear pulse has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         alarm <= 1'b0;
        else if (clr_alarm) alarm <= 1'b0;
        else if (wake_evt)  alarm <= 1'b1;
    end
endmodule

// File: rtl/uww_phase_walker.sv
// Phase walker: the pointer that moves from phase A to D after a wake.
// Assumes step_ticks is static while walking; holds at the last phase.
module uww_phase_walker
    import usb_walk_pkg::*;
#(
    parameter int TICK_W = 8,
    localparam int PTR_W = $clog2(NUM_PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_evt,
    input  logic              master_en,
    input  logic              clr_ptr,
    input  logic [TICK_W-1:0] step_ticks,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PHASES - 1);

    logic              walking;
    logic [TICK_W-1:0] tick;

    // Walk state: start on a wake, stop on a pointer clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_ptr) walking <= 1'b0;
        else if (wake_evt)     walking <= 1'b1;
    end

    // Step the pointer once per step_ticks+1 enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_ptr) begin
            ptr  <= '0;
            tick <= '0;
        end else if (master_en && walking && ptr != LAST) begin
            if (tick >= step_ticks) begin
                ptr  <= ptr + 1'b1;
                tick <= '0;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_wake_walker.sv
// Top: suspend wake walker. Debounces the line, detects wake, walks the
// per-speed phase table and drives the selected pad byte.
// Assumes all configuration inputs are synchronous to clk.
module usb_wake_walker
    import usb_walk_pkg::*;
#(
    parameter int DEB_W  = 4,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_dp,
    input  logic              line_dm,
    input  logic [1:0]        speed,
    input  logic [3:0]        wake_sel,
    input  logic              master_en,
    input  logic              line_wake_en,
    input  logic [DEB_W-1:0]  deb_cnt,
    input  logic [TICK_W-1:0] step_ticks,
    input  logic              clr_ptr,
    input  logic              clr_alarm,
    output logic              pad_pd_dp,
    output logic              pad_pd_dm,
    output logic              pad_drv_dp,
    output logic              pad_drv_dm,
    output logic              pad_hiz,
    output logic [1:0]        phase,
    output logic              wake_alarm
);
    localparam int PTR_W = $clog2(NUM_PHASES);

    logic [1:0]        stable, stable_q;
    logic              wake_evt;
    logic [PTR_W-1:0]  ptr;
    logic [TABLE_W-1:0] tbl;
    logic [BYTE_W-1:0] bytes [NUM_PHASES];
    logic [BYTE_W-1:0] sel_byte;

    uww_line_filter #(.DEB_W(DEB_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .raw({line_dp, line_dm}),
        .deb_cnt(deb_cnt), .stable(stable), .stable_q(stable_q)
    );

    uww_wake_detect u_detect (
        .clk(clk), .rst_n(rst_n), .stable(stable), .stable_q(stable_q),
        .wake_sel(wake_sel), .master_en(master_en),
        .line_wake_en(line_wake_en), .clr_alarm(clr_alarm),
        .wake_evt(wake_evt), .alarm(wake_alarm)
    );

    uww_phase_walker #(.TICK_W(TICK_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .master_en(master_en),
        .clr_ptr(clr_ptr), .step_ticks(step_ticks), .ptr(ptr)
    );

    // Table word for the saved speed.
    assign tbl = phase_table(speed_e'(speed));

    // Split the table word into per-phase bytes.
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_split
        assign bytes[g] = tbl[g*BYTE_W +: BYTE_W];
    end

    // Visible phase is A while the master enable is low.
    assign phase    = master_en ? ptr : '0;
    assign sel_byte = bytes[phase];

    // Pad controls taken from the selected byte.
    assign pad_pd_dp  = sel_byte[BIT_PD_DP];
    assign pad_pd_dm  = sel_byte[BIT_PD_DM];
    assign pad_drv_dp = sel_byte[BIT_DRV_DP];
    assign pad_drv_dm = sel_byte[BIT_DRV_DM];
    assign pad_hiz    = sel_byte[BIT_HIZ];
endmodule

// File: rtl/uww_checker.sv
// Checker: temporal properties of the walker, observed at its ports.
module uww_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] speed,
    input logic       master_en,
    input logic       line_wake_en,
    input logic       clr_ptr,
    input logic       clr_alarm,
    input logic       pad_pd_dp,
    input logic       pad_pd_dm,
    input logic       pad_drv_dp,
    input logic       pad_drv_dm,
    input logic       pad_hiz,
    input logic [1:0] phase,
    input logic       wake_alarm
);
    a_r11_master_low_phase_a: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> phase == 2'd0);

    a_r10_clear_returns_a: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ptr |=> phase == 2'd0);

    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !clr_ptr) ##1 master_en |->
            (phase == $past(phase) || phase == $past(phase) + 2'd1));

    a_r8_alarm_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_alarm) |-> $past(master_en && line_wake_en));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_alarm |=> !wake_alarm);

    a_r5_unknown_floats: assert property (@(posedge clk) disable iff (!rst_n)
        speed == 2'd3 |-> pad_hiz && !pad_drv_dp && !pad_drv_dm);

    a_r2_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_drv_dp && pad_drv_dm) && pad_pd_dp && pad_pd_dm);
endmodule

bind usb_wake_walker uww_checker u_chk (
    .clk(clk), .rst_n(rst_n), .speed(speed), .master_en(master_en),
    .line_wake_en(line_wake_en), .clr_ptr(clr_ptr), .clr_alarm(clr_alarm),
    .pad_pd_dp(pad_pd_dp), .pad_pd_dm(pad_pd_dm), .pad_drv_dp(pad_drv_dp),
    .pad_drv_dm(pad_drv_dm), .pad_hiz(pad_hiz), .phase(phase),
    .wake_alarm(wake_alarm)
);

// File: tb/test_usb_wake_walker.sv
module test_usb_wake_walker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_dp = 1'b1, line_dm = 1'b0;
    logic [1:0] speed = 2'd0;
    logic [3:0] wake_sel = 4'd15;
    logic       master_en = 1'b1, line_wake_en = 1'b1;
    logic [3:0] deb_cnt = 4'd1;
    logic [7:0] step_ticks = 8'd3;
    logic       clr_ptr = 1'b0, clr_alarm = 1'b0;
    logic       pad_pd_dp, pad_pd_dm, pad_drv_dp, pad_drv_dm, pad_hiz;
    logic [1:0] phase;
    logic       wake_alarm;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    usb_wake_walker i_usb_wake_walker (
        .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
        .speed(speed), .wake_sel(wake_sel), .master_en(master_en),
        .line_wake_en(line_wake_en), .deb_cnt(deb_cnt), .step_ticks(step_ticks),
        .clr_ptr(clr_ptr), .clr_alarm(clr_alarm), .pad_pd_dp(pad_pd_dp),
        .pad_pd_dm(pad_pd_dm), .pad_drv_dp(pad_drv_dp), .pad_drv_dm(pad_drv_dm),
        .pad_hiz(pad_hiz), .phase(phase), .wake_alarm(wake_alarm)
    );

    // Behavioural reference state.
    int m_deb, m_prev, m_run, m_ptr, m_tick;
    bit m_alarm, m_walk;

    function automatic int exp_byte(int spd, int ph);
        int j_dp = (spd <= 1);
        if (spd == 3) return 8'h43;
        if (ph == 0) return 8'h43 | (j_dp ? 8'h10 : 8'h20);
        return 8'h03 | (j_dp ? 8'h20 : 8'h10);
    endfunction

    function automatic int got_byte();
        return {25'd0, pad_hiz, pad_drv_dm, pad_drv_dp, 2'b00, pad_pd_dm, pad_pd_dp};
    endfunction

    task automatic chk(int act, int expv, string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        int raw, ev, hit;
        raw = {line_dp, line_dm};
        if (!rst_n) begin
            m_deb = raw; m_prev = raw; m_run = 0;
            m_alarm = 0; m_walk = 0; m_ptr = 0; m_tick = 0;
        end else begin
            if (wake_sel == 15) hit = (m_deb != m_prev);
            else if (wake_sel < 4) hit = (m_deb == wake_sel);
            else hit = 0;
            ev = hit && master_en && line_wake_en;
            m_prev = m_deb;
            if (raw == m_deb) m_run = 0;
            else if (m_run >= deb_cnt) begin m_deb = raw; m_run = 0; end
            else m_run++;
            if (clr_alarm) m_alarm = 0; else if (ev) m_alarm = 1;
            if (clr_ptr) begin
                m_walk = 0; m_ptr = 0; m_tick = 0;
            end else begin
                if (master_en && m_walk && m_ptr != 3) begin
                    if (m_tick >= step_ticks) begin m_ptr++; m_tick = 0; end
                    else m_tick++;
                end
                if (ev) m_walk = 1;
            end
        end
    end

    // Compare every cycle away from the edge.
    always @(negedge clk) begin
        int eph;
        if (rst_n) begin
            eph = master_en ? m_ptr : 0;
            chk(phase, eph, "R9/R11 phase");
            chk(wake_alarm, m_alarm, "R8 alarm");
            chk(got_byte(), exp_byte(speed, eph), "R2 pad byte");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_ptr();
        clr_ptr = 1; cyc(1); clr_ptr = 0;
    endtask

    task automatic pulse_alarm();
        clr_alarm = 1; cyc(1); clr_alarm = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        // R1 reset state, R3 J byte
        chk(phase, 0, "R1 phase"); chk(wake_alarm, 0, "R1 alarm");
        chk(got_byte(), 8'h53, "R1/R3 phase A byte");
        // R6 one-cycle glitch ignored (deb_cnt=1)
        line_dp = 0; cyc(1); line_dp = 1; cyc(6);
        chk(wake_alarm, 0, "R6 glitch ignored");
        // R9 wake to K and walk to D
        line_dp = 0; line_dm = 1; cyc(40);
        chk(wake_alarm, 1, "R8 alarm set");
        chk(phase, 3, "R9 holds at D");
        chk(got_byte(), 8'h23, "R3 K byte");
        // R8 clear alarm, walk unaffected; R10 clear pointer
        pulse_alarm(); chk(wake_alarm, 0, "R8 clear"); chk(phase, 3, "R8 phase kept");
        pulse_ptr(); chk(phase, 0, "R10 back to A");
        cyc(10); chk(phase, 0, "R10 walk stopped");
        // R8 no latch with line wake disabled
        line_wake_en = 0; line_dp = 1; line_dm = 0; cyc(8);
        chk(wake_alarm, 0, "R8 line wake off");
        line_wake_en = 1;
        // R11 master low, R4 low-speed bytes
        master_en = 0; speed = 2; line_dp = 0; line_dm = 1; cyc(8);
        chk(wake_alarm, 0, "R8 master off");
        chk(got_byte(), 8'h63, "R4 phase A byte");
        master_en = 1;
        // R7 code 12 never wakes
        wake_sel = 12; line_dp = 1; line_dm = 0; cyc(8);
        line_dp = 0; line_dm = 1; cyc(8);
        chk(wake_alarm, 0, "R7 code 12");
        // R7 code 6 never wakes
        wake_sel = 6; line_dp = 1; line_dm = 0; cyc(8);
        chk(wake_alarm, 0, "R7 code 6");
        // R7 level match code 2 = {dp,dm}=10
        wake_sel = 12; line_dp = 0; line_dm = 1; cyc(6);
        wake_sel = 2; cyc(4); chk(wake_alarm, 0, "R7 no match");
        line_dp = 1; line_dm = 0; cyc(40);
        chk(wake_alarm, 1, "R7 level match");
        chk(got_byte(), 8'h13, "R4 K byte");
        // R11 freeze mid walk
        wake_sel = 12; pulse_alarm(); pulse_ptr();
        step_ticks = 20; wake_sel = 15; line_dp = 0; line_dm = 1; cyc(30);
        chk(phase, 1, "R9 first step");
        master_en = 0; cyc(60); chk(phase, 0, "R11 frozen");
        master_en = 1; #0; chk(phase, 1, "R11 resumes");
        cyc(60); chk(phase, 3, "R11 reaches D");
        // R10 clear concurrent with wake
        pulse_ptr(); step_ticks = 2;
        line_dp = 1; line_dm = 0; cyc(1); cyc(1);
        clr_ptr = 1; cyc(1); clr_ptr = 0; cyc(20);
        chk(phase, 0, "R10 clear wins");
        // R5 unknown speed
        speed = 3; pulse_ptr(); chk(got_byte(), 8'h43, "R5 phase A");
        line_dp = 0; line_dm = 1; cyc(30);
        chk(phase, 3, "R5 walked"); chk(got_byte(), 8'h43, "R5 phase D");
        // R6 longer debounce
        speed = 0; pulse_ptr(); pulse_alarm(); deb_cnt = 4; cyc(4);
        line_dp = 1; line_dm = 0; cyc(4); line_dp = 0; line_dm = 1; cyc(10);
        chk(wake_alarm, 0, "R6 short pulse");
        line_dp = 1; line_dm = 0; cyc(8);
        chk(wake_alarm, 1, "R6 held change");
        cyc(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule